// File: doc/BRIEF.md
# Set-Associative Cache Tag and Replacement Controller

This block holds the tag, valid, dirty and recency state of a set-associative cache and decides, one request at a time, whether an access hits. A request carries a byte address, an access kind (instruction fetch, load, store, writeback or prefetch) and a per-request choice between least-recently-used and counter-driven pseudo-random replacement. The controller takes the set index and the tag from the address and compares the tag against every way of that set at once. It then updates the dirty and recency state. On a miss it picks a way to refill and reports the block address of any dirty line that the refill pushes out.

No data array is modelled. The surrounding cache uses the hit/miss flags and the writeback address to drive its own data path and refill logic. Two running counters, one for accepted requests and one for hits, allow the totals to be compared against a software model of the cache.

Top module: `cache_tag_ctrl`

## Requirements
- R1: With default parameters (16-byte lines, 8 sets, 4 ways, 32-bit address), bits [3:0] are the byte offset and are ignored for lookup. Bits [6:4] select the set and bits [31:7] form the tag.
- R2: An access hits only when a way of the indexed set is valid and holds the same tag. `rsp_hit` reports this in the cycle after the request is accepted.
- R3: A hit by a store (kind 2) or a writeback (kind 3) marks the line dirty. A hit by a fetch (0), load (1) or prefetch (4) leaves the dirty bit as it was.
- R4: When an access hits with `req_policy` = 0 (LRU), the hit way becomes most recent. Each way that was more recent than it moves one place toward least recent.
- R5: On a miss, the lowest-numbered invalid way of the set is filled if one exists. A valid way is evicted only when none is invalid. Once a miss finds no invalid way, the set is marked full.
- R6: When a miss with `req_policy` = 0 finds the set full, it evicts the least-recent way. The refilled way then becomes most recent.
- R7: When a miss with `req_policy` = 1 (random) finds the set full, it evicts the way numbered by a single counter shared by all sets. The counter starts at 0 and advances by one, modulo the way count, on each such eviction. Accesses with `req_policy` = 1 leave the recency order unchanged.
- R8: When the evicted way was valid and dirty, `wb_valid` is 1 and `wb_addr` = {stored tag, set index, 4'b0}. Otherwise `wb_valid` and `wb_addr` are both zero.
- R9: A refilled way becomes valid with the new tag. It is dirty when the access was a store or a writeback, and clean otherwise.
- R10: `rsp_miss` is 1 only for a missing fetch, load or store. Writeback and prefetch misses still refill a way but leave `rsp_miss` at 0. Kind codes 5 to 7 behave like a load.
- R11: After synchronous reset, every way is invalid and clean and no set is full. The recency order of every set runs from way 0 (most recent) to way 3 (least recent). The random counter and both totals are zero, and all response outputs are zero.
- R12: `acc_count` increases by one for each accepted request. `hit_count` increases by one for each accepted request that hits.
- R13: `req_ready` is 1 whenever reset is low, so one request can be accepted in every cycle. `rsp_valid` is 1 only in the cycle after an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_kind | input | 3 | 0 fetch, 1 load, 2 store, 3 writeback, 4 prefetch |
| req_policy | input | 1 | 0 LRU, 1 random replacement |
| rsp_valid | output | 1 | Response flags below belong to the previous accepted request |
| rsp_hit | output | 1 | Access hit |
| rsp_miss | output | 1 | Access missed and counts as a miss |
| wb_valid | output | 1 | A dirty line was evicted |
| wb_addr | output | ADDR_W | Block address of the evicted dirty line, zero otherwise |
| acc_count | output | CNT_W | Accepted requests since reset |
| hit_count | output | CNT_W | Hits since reset |

## Verification
Every response output and both totals are registered once. Their values for a request accepted at one rising edge can therefore be read after that edge. The bench drives each request on a falling edge and compares all outputs on the next falling edge, half a period after the accepting edge. Requests are sent back to back, so each comparison is made just before the next request is accepted, and state changes from one request are visible to the next. Idle gaps are compared on the same falling-edge schedule to confirm that `rsp_valid` drops one cycle after the last acceptance.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    typedef enum logic [2:0] {
        ACC_FETCH = 3'd0,
        ACC_LOAD  = 3'd1,
        ACC_STORE = 3'd2,
        ACC_WBACK = 3'd3,
        ACC_PREF  = 3'd4
    } acc_kind_e;

    typedef enum logic {
        POL_LRU  = 1'b0,
        POL_RAND = 1'b1
    } repl_pol_e;

    typedef struct packed {
        logic hit;
        logic miss;
        logic wb;
    } rsp_flags_t;

    // Store and writeback make a line dirty.
    function automatic logic kind_marks_dirty(input logic [2:0] kind);
        return (kind == ACC_STORE) || (kind == ACC_WBACK);
    endfunction

    // Writeback and prefetch misses are not reported as misses.
    function automatic logic kind_counts_miss(input logic [2:0] kind);
        return !((kind == ACC_WBACK) || (kind == ACC_PREF));
    endfunction

endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
    parameter int BLK_W = 28,
    parameter int IDX_W = 3,
    parameter int TAG_W = BLK_W - IDX_W
) (
    input  logic [BLK_W-1:0] blk_addr_i,
    output logic [IDX_W-1:0] set_idx_o,
    output logic [TAG_W-1:0] tag_o
);
    assign set_idx_o = blk_addr_i[IDX_W-1:0];
    assign tag_o     = blk_addr_i[BLK_W-1 -: TAG_W];
endmodule

// File: rtl/cache_way_match.sv
module cache_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 25,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag_i,
    input  logic [WAYS-1:0]            way_vld_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           hit_way_o,
    output logic                       free_o,
    output logic [WAY_W-1:0]           free_way_o
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_vld_i[g] && (way_tag_i[g] == tag_i);
    end

    assign hit_o  = |match;
    assign free_o = ~&way_vld_i;

    // Lowest-numbered way wins in both encoders.
    always_comb begin
        hit_way_o  = '0;
        free_way_o = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i])     hit_way_o  = WAY_W'(i);
            if (!way_vld_i[i]) free_way_o = WAY_W'(i);
        end
    end
endmodule

// File: rtl/cache_recency.sv
module cache_recency #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][WAY_W-1:0] order_i,
    input  logic [WAY_W-1:0]           touch_i,
    output logic [WAYS-1:0][WAY_W-1:0] order_o,
    output logic [WAY_W-1:0]           lru_o
);
    logic [WAY_W-1:0] pos;

    // Position 0 is most recent, position WAYS-1 least recent.
    assign lru_o = order_i[WAYS-1];

    always_comb begin
        pos = '0;
        for (int p = 0; p < WAYS; p++) begin
            if (order_i[p] == touch_i) pos = WAY_W'(p);
        end
    end

    always_comb begin
        order_o[0] = touch_i;
        for (int k = 1; k < WAYS; k++) begin
            order_o[k] = (WAY_W'(k) <= pos) ? order_i[k-1] : order_i[k];
        end
    end
endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
    parameter int WAY_W = 2
) (
    input  logic             full_i,
    input  logic             free_i,
    input  logic [WAY_W-1:0] free_way_i,
    input  logic             pol_rand_i,
    input  logic [WAY_W-1:0] lru_way_i,
    input  logic [WAY_W-1:0] rnd_way_i,
    output logic [WAY_W-1:0] victim_o,
    output logic             evict_rand_o
);
    logic use_free;

    assign use_free     = !full_i && free_i;
    assign evict_rand_o = !use_free && pol_rand_i;

    always_comb begin
        if (use_free)        victim_o = free_way_i;
        else if (pol_rand_i) victim_o = rnd_way_i;
        else                 victim_o = lru_way_i;
    end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
    import cache_tag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int NUM_SETS   = 8,
    parameter int WAYS       = 4,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_kind,
    input  logic              req_policy,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [CNT_W-1:0]  acc_count,
    output logic [CNT_W-1:0]  hit_count
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(NUM_SETS);
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int TAG_W = BLK_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    // Per-set state
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [NUM_SETS];
    logic [WAYS-1:0]            valid_q [NUM_SETS];
    logic [WAYS-1:0]            dirty_q [NUM_SETS];
    logic [WAYS-1:0][WAY_W-1:0] order_q [NUM_SETS];
    logic [NUM_SETS-1:0]        full_q;
    logic [WAY_W-1:0]           rnd_ctr_q;

    logic              accept;
    logic [IDX_W-1:0]  set_idx;
    logic [TAG_W-1:0]  req_tag;
    logic              hit, free_any;
    logic [WAY_W-1:0]  hit_way, free_way, lru_way, victim, touch_way;
    logic              evict_rand;
    logic [WAYS-1:0][WAY_W-1:0] order_new;
    logic              victim_dirty;
    logic [ADDR_W-1:0] wb_addr_d;
    logic              marks_dirty;
    rsp_flags_t        flags_d;
    logic              unused_offset;

    assign req_ready     = !rst;
    assign accept        = req_valid && req_ready;
    assign unused_offset = ^req_addr[OFF_W-1:0];
    assign marks_dirty   = kind_marks_dirty(req_kind);

    cache_addr_split #(.BLK_W(BLK_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) split_i (
        .blk_addr_i (req_addr[ADDR_W-1:OFF_W]),
        .set_idx_o  (set_idx),
        .tag_o      (req_tag)
    );

    cache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) match_i (
        .way_tag_i  (tag_q[set_idx]),
        .way_vld_i  (valid_q[set_idx]),
        .tag_i      (req_tag),
        .hit_o      (hit),
        .hit_way_o  (hit_way),
        .free_o     (free_any),
        .free_way_o (free_way)
    );

    cache_victim_pick #(.WAY_W(WAY_W)) pick_i (
        .full_i       (full_q[set_idx]),
        .free_i       (free_any),
        .free_way_i   (free_way),
        .pol_rand_i   (req_policy == POL_RAND),
        .lru_way_i    (lru_way),
        .rnd_way_i    (rnd_ctr_q),
        .victim_o     (victim),
        .evict_rand_o (evict_rand)
    );

    assign touch_way = hit ? hit_way : victim;

    cache_recency #(.WAYS(WAYS), .WAY_W(WAY_W)) rec_i (
        .order_i (order_q[set_idx]),
        .touch_i (touch_way),
        .order_o (order_new),
        .lru_o   (lru_way)
    );

    assign victim_dirty = valid_q[set_idx][victim] && dirty_q[set_idx][victim];
    assign wb_addr_d    = {tag_q[set_idx][victim], set_idx, {OFF_W{1'b0}}};

    always_comb begin
        flags_d.hit  = accept && hit;
        flags_d.miss = accept && !hit && kind_counts_miss(req_kind);
        flags_d.wb   = accept && !hit && victim_dirty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                tag_q[s]   <= '0;
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                for (int p = 0; p < WAYS; p++) order_q[s][p] <= WAY_W'(p);
            end
            full_q    <= '0;
            rnd_ctr_q <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            wb_valid  <= 1'b0;
            wb_addr   <= '0;
            acc_count <= '0;
            hit_count <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_hit   <= flags_d.hit;
            rsp_miss  <= flags_d.miss;
            wb_valid  <= flags_d.wb;
            wb_addr   <= flags_d.wb ? wb_addr_d : '0;
            if (accept) begin
                acc_count <= acc_count + CNT_W'(1);
                if (hit) begin
                    hit_count <= hit_count + CNT_W'(1);
                    if (marks_dirty) dirty_q[set_idx][hit_way] <= 1'b1;
                end else begin
                    tag_q[set_idx][victim]   <= req_tag;
                    valid_q[set_idx][victim] <= 1'b1;
                    dirty_q[set_idx][victim] <= marks_dirty;
                    if (!free_any) full_q[set_idx] <= 1'b1;
                    if (evict_rand) rnd_ctr_q <= rnd_ctr_q + WAY_W'(1);
                end
                if (req_policy == POL_LRU) order_q[set_idx] <= order_new;
            end
        end
    end

    // ---------------- assertions ----------------
    logic [WAYS-1:0] order_seen;
    always_comb begin
        order_seen = '0;
        for (int p = 0; p < WAYS; p++) order_seen[order_new[p]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst && accept && req_policy == POL_LRU) begin
            AST_ORDER_PERMUTATION: assert (&order_seen); // R4
        end
    end

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(accept)); // R13
    AST_HIT_MISS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> !rsp_miss && rsp_valid); // R2
    AST_WB_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        !wb_valid |-> wb_addr == '0); // R8
    AST_WB_NOT_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> !rsp_hit && rsp_valid); // R8
    AST_FULL_HAS_NO_FREE: assert property (@(posedge clk) disable iff (rst)
        accept && full_q[set_idx] |-> !free_any); // R5
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
        accept |=> acc_count == $past(acc_count) + CNT_W'(1)); // R12
endmodule

// File: tb/cache_tag_ctrl_tb_top.sv
module cache_tag_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;
    localparam int SETS = 8;
    localparam int WAYS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_kind = '0;
    logic        req_policy = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, wb_valid;
    logic [31:0] wb_addr;
    logic [15:0] acc_count, hit_count;

    int checks = 0;
    int errors = 0;

    // reference state
    int unsigned m_tag   [SETS][WAYS];
    bit          m_valid [SETS][WAYS];
    bit          m_dirty [SETS][WAYS];
    int          m_order [SETS][WAYS];
    int          m_ctr;
    int          exp_acc, exp_hits;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_tag_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .req_policy(req_policy),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .wb_valid(wb_valid), .wb_addr(wb_addr),
        .acc_count(acc_count), .hit_count(hit_count)
    );

    function automatic logic [31:0] mk_addr(input int unsigned tag, input int set, input int off);
        return {tag[24:0], set[2:0], off[3:0]};
    endfunction

    task automatic chk(input bit ok, input string lbl, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_tag[s][w] = 0; m_valid[s][w] = 0; m_dirty[s][w] = 0; m_order[s][w] = w;
            end
        m_ctr = 0; exp_acc = 0; exp_hits = 0;
    endtask

    task automatic touch(input int s, input int w);
        int p = 0;
        for (int k = 0; k < WAYS; k++) if (m_order[s][k] == w) p = k;
        for (int k = p; k > 0; k--) m_order[s][k] = m_order[s][k-1];
        m_order[s][0] = w;
    endtask

    task automatic model(input logic [31:0] a, input int kind, input bit pol,
                         output bit eh, output bit em, output bit ewv, output logic [31:0] ewa);
        int s = int'(a[6:4]);
        int unsigned t = a[31:7];
        int hw = -1;
        int v = -1;
        bit dty = (kind == 2) || (kind == 3);
        for (int w = 0; w < WAYS; w++)
            if (hw < 0 && m_valid[s][w] && m_tag[s][w] == t) hw = w;
        eh = (hw >= 0); em = 0; ewv = 0; ewa = '0;
        exp_acc++;
        if (eh) begin
            exp_hits++;
            if (dty) m_dirty[s][hw] = 1;
            if (!pol) touch(s, hw);
        end else begin
            em = !(kind == 3 || kind == 4);
            for (int w = 0; w < WAYS; w++) if (v < 0 && !m_valid[s][w]) v = w;
            if (v < 0) begin
                if (pol) begin v = m_ctr; m_ctr = (m_ctr + 1) % WAYS; end
                else v = m_order[s][WAYS-1];
            end
            if (m_valid[s][v] && m_dirty[s][v]) begin
                ewv = 1; ewa = mk_addr(m_tag[s][v], s, 0);
            end
            m_tag[s][v] = t; m_valid[s][v] = 1; m_dirty[s][v] = dty;
            if (!pol) touch(s, v);
        end
    endtask

    task automatic send(input logic [31:0] a, input int kind, input bit pol, input string lbl);
        bit eh, em, ewv;
        logic [31:0] ewa;
        req_valid = 1'b1; req_addr = a; req_kind = kind[2:0]; req_policy = pol;
        model(a, kind, pol, eh, em, ewv, ewa);
        @(negedge clk);
        chk(rsp_valid && rsp_hit == eh && rsp_miss == em && wb_valid == ewv && wb_addr == ewa, lbl,
            {28'd0, rsp_valid, rsp_hit, rsp_miss, wb_valid, wb_addr},
            {28'd0, 1'b1, eh, em, ewv, ewa});
        chk(acc_count == 16'(exp_acc) && hit_count == 16'(exp_hits), "R12 totals",
            {32'd0, acc_count, hit_count}, {32'd0, 16'(exp_acc), 16'(exp_hits)});
    endtask

    task automatic idle(input string lbl);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!rsp_valid && !rsp_hit && !rsp_miss && !wb_valid && req_ready, lbl,
            {59'd0, req_ready, rsp_valid, rsp_hit, rsp_miss, wb_valid},
            {59'd0, 1'b1, 4'b0000});
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", WD_CYCLES, WD_CYCLES);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state visible at the ports
        chk(!rsp_valid && !rsp_hit && !rsp_miss && !wb_valid && wb_addr == 0 &&
            acc_count == 0 && hit_count == 0 && req_ready, "R11 reset outputs",
            {acc_count, hit_count, wb_addr}, 64'd0);

        // R5 R9: fill set 2 with stores, no evictions yet
        for (int t = 1; t <= 4; t++) send(mk_addr(t, 2, 0), 2, 0, "R5 R9 fill");
        // R1: other offsets of a stored line hit; top tag bit separates lines
        send(mk_addr(1, 2, 15), 1, 0, "R1 offset ignored");
        send(mk_addr(1 | (1 << 24), 2, 0), 1, 0, "R1 tag top bit");
        // R4 R6 R8: LRU evictions of dirty lines
        send(mk_addr(3, 2, 7), 1, 0, "R4 hit to MRU");
        send(mk_addr(20, 2, 0), 0, 0, "R6 R8 lru evict");
        send(mk_addr(21, 2, 0), 1, 0, "R6 R8 lru evict");
        // R10: prefetch and writeback misses allocate without a miss flag
        send(mk_addr(30, 2, 0), 4, 0, "R10 prefetch miss");
        send(mk_addr(31, 2, 0), 3, 0, "R10 writeback miss");
        send(mk_addr(30, 2, 0), 1, 0, "R10 prefetch allocated");
        idle("R13 idle after burst");
        // R3: load hits keep a line clean, store hit dirties it
        send(mk_addr(40, 6, 0), 1, 0, "R3 clean fill");
        send(mk_addr(40, 6, 0), 1, 0, "R3 load hit");
        send(mk_addr(41, 6, 0), 2, 0, "R3 store fill");
        send(mk_addr(42, 6, 0), 1, 0, "R3 fill");
        send(mk_addr(43, 6, 0), 1, 0, "R3 fill");
        send(mk_addr(42, 6, 0), 2, 0, "R3 store hit");
        for (int t = 50; t < 54; t++) send(mk_addr(t, 6, 0), 1, 0, "R3 R8 eviction wb");
        // R7: random policy on set 5 and LRU order left untouched
        for (int t = 60; t < 64; t++) send(mk_addr(t, 5, 0), 2, 1, "R7 fill random");
        for (int t = 64; t < 70; t++) send(mk_addr(t, 5, 0), 2, 1, "R7 random evict");
        send(mk_addr(70, 5, 0), 1, 0, "R7 lru after random");
        idle("R13 idle");

        // constrained random mix
        for (int n = 0; n < 1500; n++) begin
            int s = ($urandom % 4 == 0) ? int'($urandom % SETS) : int'($urandom % 2);
            int unsigned t = $urandom % 7;
            int k = int'($urandom % 5);
            bit p = ($urandom % 3 == 0);
            send(mk_addr(t, s, int'($urandom % 16)), k, p, "R2 R5 R6 R7 R8 R10 random");
            if ($urandom % 16 == 0) idle("R13 random idle");
        end
        idle("R13 final idle");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule